// File: doc/BRIEF.md
# DSP Pointer Update Unit

This block generates operand addresses for a signal-processing datapath. It holds a bank of pointer registers and a smaller bank of signed index registers. Each of several access ports names a pointer register and an update mode. In the same cycle the port receives that pointer's current value as its memory address, and the updated pointer is written back at the next clock edge. No extra cycle is spent on address arithmetic.

Four updates are supported: add one element, subtract one element, add a selected index register, and a reverse-carry increment. In the reverse-carry increment the carry ripples from the top of a configurable low field toward bit 0. This walks an FFT buffer in bit-reversed order at full rate. A separate load path initialises pointer and index registers.

The ports carry no handshake. A port with its enable high performs an access every cycle, and an idle port has no effect.

Top module: `dsp_agu`

## Requirements
- R1: Mode code 0 (hold) drives the selected pointer onto the port's address and leaves that pointer unchanged.
- R2: Mode code 1 drives the current pointer as the address, and the pointer becomes pointer + ESIZE (default 2), modulo 2^AW, after the clock edge.
- R3: Mode code 2 drives the current pointer as the address, and the pointer becomes pointer - ESIZE modulo 2^AW, so 0 wraps to 0xFFFE with the defaults.
- R4: Mode code 3 drives the current pointer as the address, and the pointer becomes pointer plus the two's-complement value of the index register named by the port's index select.
- R5: Mode code 4 adds one to the low `rev_span` bits of the pointer with the carry travelling from bit `rev_span`-1 toward bit 0. With span 3 and low bits starting at 0, the low bits step 0,4,2,6,1,5,3,7 and then wrap to 0.
- R6: In mode 4, pointer bits at and above `rev_span` never change, and a span of 0 leaves the pointer unchanged.
- R7: The address output of a port is combinational from the current register state, and the update costs no extra cycle: a pointer updated at one edge is presented by the very next access.
- R8: Up to NPORT (default 3) ports, each with its own pointer, mode and index select, update different pointers in the same cycle.
- R9: When several enabled ports select the same pointer in one cycle, only the update of the lowest-numbered port among them takes effect.
- R10: With `ld_en` high, `ld_data` is written at the clock edge into pointer `ld_reg` (`ld_kind`=0) or index register `ld_reg` (`ld_kind`=1). A pointer load overrides any port update of the same pointer in that cycle, and an index load leaves the pointers unchanged.
- R11: After reset every pointer and index register reads 0.
- R12: Mode codes 5, 6 and 7 behave as hold: the pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_span | input | $clog2(AW+1) | Number of low pointer bits used by the reverse-carry mode |
| acc_en | input | NPORT | Per-port access enable |
| acc_ptr | input | NPORT x $clog2(NPTR) | Per-port pointer register select |
| acc_mode | input | NPORT x 3 | Per-port update mode code |
| acc_idx | input | NPORT x $clog2(NIDX) | Per-port index register select for mode 3 |
| acc_addr | output | NPORT x AW | Per-port address, the current pointer value |
| ld_en | input | 1 | Register load strobe |
| ld_kind | input | 1 | 0 loads a pointer register, 1 loads an index register |
| ld_reg | input | max($clog2(NPTR),$clog2(NIDX)) | Register number to load |
| ld_data | input | AW | Value to load |

## Verification
An address is valid in the same cycle as its access. A pointer update or a register load becomes visible after exactly one rising edge. The bench changes inputs on the falling edge and samples each address 1 ns later, before the next rising edge. It then reads the written-back pointer through a hold access on port 0 one cycle later. Bit-reversed walks are compared cycle by cycle against a model in the bench that reverses the field, adds one and reverses it back. This is a different method from the carry ripple in the design.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_HOLD = 3'd0,
    AM_INC  = 3'd1,
    AM_DEC  = 3'd2,
    AM_IDX  = 3'd3,
    AM_REV  = 3'd4
  } agu_mode_e;
endpackage

// File: rtl/agu_next.sv
module agu_next
  import agu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int ESIZE = 2,
  parameter int SPW   = 5
) (
  input  logic [AW-1:0]  cur,
  input  logic [2:0]     mode,
  input  logic [AW-1:0]  idx_val,
  input  logic [SPW-1:0] span,
  output logic [AW-1:0]  nxt
);
  localparam logic [AW-1:0] STEP = AW'(ESIZE);

  logic [AW-1:0] rev_nxt;
  logic          carry;

  // reverse-carry: carry starts at bit span-1 and moves toward bit 0
  always_comb begin
    rev_nxt = cur;
    carry   = 1'b1;
    for (int i = AW - 1; i >= 0; i--) begin
      if (i < int'(span)) begin
        rev_nxt[i] = cur[i] ^ carry;
        carry      = carry & cur[i];
      end
    end
  end

  always_comb begin
    case (mode)
      AM_INC:  nxt = cur + STEP;
      AM_DEC:  nxt = cur - STEP;
      AM_IDX:  nxt = cur + idx_val;
      AM_REV:  nxt = rev_nxt;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int AW    = 16,
  parameter int NPTR  = 8,
  parameter int NIDX  = 4,
  parameter int NPORT = 3,
  parameter int PSW   = 3,
  parameter int ISW   = 2,
  parameter int RSW   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0]            we,
  input  logic [NPORT-1:0][PSW-1:0]   wsel,
  input  logic [NPORT-1:0][AW-1:0]    wdat,
  input  logic                        ld_en,
  input  logic                        ld_kind,
  input  logic [RSW-1:0]              ld_reg,
  input  logic [AW-1:0]               ld_data,
  output logic [NPTR-1:0][AW-1:0]     ptr_q,
  output logic [NIDX-1:0][AW-1:0]     idx_q
);
  logic [NPTR-1:0][AW-1:0] ptr_d;
  logic [NIDX-1:0][AW-1:0] idx_d;

  // highest port first so the lowest-numbered port is applied last and wins
  always_comb begin
    ptr_d = ptr_q;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (we[p]) ptr_d[wsel[p]] = wdat[p];
    end
    if (ld_en && !ld_kind) ptr_d[ld_reg[PSW-1:0]] = ld_data;
  end

  always_comb begin
    idx_d = idx_q;
    if (ld_en && ld_kind) idx_d[ld_reg[ISW-1:0]] = ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      idx_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW    = 16,
  parameter int NPTR  = 8,
  parameter int NIDX  = 4,
  parameter int NPORT = 3,
  parameter int ESIZE = 2,
  localparam int PSW  = $clog2(NPTR),
  localparam int ISW  = $clog2(NIDX),
  localparam int RSW  = (PSW > ISW) ? PSW : ISW,
  localparam int SPW  = $clog2(AW + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SPW-1:0]            rev_span,
  input  logic [NPORT-1:0]          acc_en,
  input  logic [NPORT-1:0][PSW-1:0] acc_ptr,
  input  logic [NPORT-1:0][2:0]     acc_mode,
  input  logic [NPORT-1:0][ISW-1:0] acc_idx,
  output logic [NPORT-1:0][AW-1:0]  acc_addr,
  input  logic                      ld_en,
  input  logic                      ld_kind,
  input  logic [RSW-1:0]            ld_reg,
  input  logic [AW-1:0]             ld_data
);
  logic [NPTR-1:0][AW-1:0]  ptr_q;
  logic [NIDX-1:0][AW-1:0]  idx_q;
  logic [NPORT-1:0][AW-1:0] nxt;

  agu_regfile #(
    .AW(AW), .NPTR(NPTR), .NIDX(NIDX), .NPORT(NPORT),
    .PSW(PSW), .ISW(ISW), .RSW(RSW)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (acc_en),
    .wsel    (acc_ptr),
    .wdat    (nxt),
    .ld_en   (ld_en),
    .ld_kind (ld_kind),
    .ld_reg  (ld_reg),
    .ld_data (ld_data),
    .ptr_q   (ptr_q),
    .idx_q   (idx_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign acc_addr[p] = ptr_q[acc_ptr[p]];

    agu_next #(.AW(AW), .ESIZE(ESIZE), .SPW(SPW)) u_next (
      .cur     (ptr_q[acc_ptr[p]]),
      .mode    (acc_mode[p]),
      .idx_val (idx_q[acc_idx[p]]),
      .span    (rev_span),
      .nxt     (nxt[p])
    );
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW    = 16,
  parameter int NPTR  = 8,
  parameter int NIDX  = 4,
  parameter int NPORT = 3,
  parameter int ESIZE = 2,
  parameter int PSW   = 3,
  parameter int ISW   = 2,
  parameter int RSW   = 3,
  parameter int SPW   = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SPW-1:0]            rev_span,
  input logic [NPORT-1:0]          acc_en,
  input logic [NPORT-1:0][PSW-1:0] acc_ptr,
  input logic [NPORT-1:0][2:0]     acc_mode,
  input logic [NPORT-1:0][ISW-1:0] acc_idx,
  input logic [NPORT-1:0][AW-1:0]  acc_addr,
  input logic                      ld_en,
  input logic                      ld_kind,
  input logic [RSW-1:0]            ld_reg,
  input logic [AW-1:0]             ld_data,
  input logic [NPTR-1:0][AW-1:0]   ptr_q,
  input logic [NIDX-1:0][AW-1:0]   idx_q
);
  logic          hit0;
  logic          go0;
  logic [AW-1:0] span_mask;

  assign hit0      = ld_en && !ld_kind && (ld_reg[PSW-1:0] == acc_ptr[0]);
  assign go0       = acc_en[0] && !hit0;
  assign span_mask = (AW'(1) << rev_span) - AW'(1);

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    go0 && (acc_mode[0] == 3'd0) |=> ptr_q[$past(acc_ptr[0])] == $past(acc_addr[0])); // R1
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go0 && (acc_mode[0] == 3'd1) |=> ptr_q[$past(acc_ptr[0])] == $past(acc_addr[0]) + AW'(ESIZE)); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go0 && (acc_mode[0] == 3'd2) |=> ptr_q[$past(acc_ptr[0])] == $past(acc_addr[0]) - AW'(ESIZE)); // R3
  AST_IDX_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    go0 && (acc_mode[0] == 3'd3) |=>
      ptr_q[$past(acc_ptr[0])] == $past(acc_addr[0]) + $past(idx_q[acc_idx[0]])); // R4
  AST_REV_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    go0 && (acc_mode[0] == 3'd4) |=>
      (ptr_q[$past(acc_ptr[0])] & ~$past(span_mask)) == ($past(acc_addr[0]) & ~$past(span_mask))); // R6
  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !ld_kind |=> ptr_q[$past(ld_reg[PSW-1:0])] == $past(ld_data)); // R10
  AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    go0 && (acc_mode[0] >= 3'd5) |=> ptr_q[$past(acc_ptr[0])] == $past(acc_addr[0])); // R12
endmodule

bind dsp_agu agu_chk #(
  .AW(AW), .NPTR(NPTR), .NIDX(NIDX), .NPORT(NPORT), .ESIZE(ESIZE),
  .PSW(PSW), .ISW(ISW), .RSW(RSW), .SPW(SPW)
) u_chk (.*);

// File: tb/dsp_agu_tb.sv
module dsp_agu_tb;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      span = '0;
  logic [2:0]      en = '0;
  logic [2:0][2:0] ptr = '0;
  logic [2:0][2:0] mode = '0;
  logic [2:0][1:0] idx = '0;
  logic [2:0][15:0] addr;
  logic            ld_en = 1'b0;
  logic            ld_kind = 1'b0;
  logic [2:0]      ld_reg = '0;
  logic [15:0]     ld_data = '0;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dsp_agu u_dut (
    .clk(clk), .rst_n(rst_n), .rev_span(span),
    .acc_en(en), .acc_ptr(ptr), .acc_mode(mode), .acc_idx(idx), .acc_addr(addr),
    .ld_en(ld_en), .ld_kind(ld_kind), .ld_reg(ld_reg), .ld_data(ld_data)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    en = '0;
    ld_en = 1'b0;
  endtask

  task automatic load(input bit kind, input int r, input logic [15:0] v);
    ld_en = 1'b1; ld_kind = kind; ld_reg = 3'(r); ld_data = v;
    step();
  endtask

  task automatic peek(input int r, output logic [15:0] v);
    en[0] = 1'b1; mode[0] = 3'd0; ptr[0] = 3'(r);
    #1 v = addr[0];
    en[0] = 1'b0;
  endtask

  task automatic acc0(input int r, input int m, input int ix);
    en[0] = 1'b1; ptr[0] = 3'(r); mode[0] = 3'(m); idx[0] = 2'(ix);
  endtask

  // model: reverse the low s bits, add one, reverse back
  function automatic logic [15:0] rev_model(input logic [15:0] p, input int s);
    logic [15:0] r, o;
    r = '0;
    for (int i = 0; i < s; i++) r[s-1-i] = p[i];
    r = r + 16'd1;
    o = p;
    for (int i = 0; i < s; i++) o[i] = r[s-1-i];
    return o;
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    for (int r = 0; r < 8; r++) begin
      peek(r, v);
      chk_eq("R11 reset pointer", v, 16'h0000);
    end
  endtask

  task automatic t_single();
    logic [15:0] v;
    load(0, 1, 16'h0100);
    acc0(1, 1, 0);
    #1 chk_eq("R7 address same cycle", addr[0], 16'h0100);
    step();
    peek(1, v); chk_eq("R2 post-increment", v, 16'h0102);
    acc0(1, 1, 0); step();
    acc0(1, 2, 0);
    #1 chk_eq("R7 next access sees update", addr[0], 16'h0104);
    step();
    peek(1, v); chk_eq("R3 post-decrement", v, 16'h0102);
    load(0, 2, 16'h0000);
    acc0(2, 2, 0); step();
    peek(2, v); chk_eq("R3 decrement wrap", v, 16'hFFFE);
    acc0(1, 0, 0); step();
    peek(1, v); chk_eq("R1 hold", v, 16'h0102);
    load(1, 3, 16'hFFFA);
    acc0(1, 3, 3); step();
    peek(1, v); chk_eq("R4 negative index", v, 16'h00FC);
    load(1, 0, 16'h0010);
    acc0(1, 3, 0); step();
    peek(1, v); chk_eq("R4 positive index", v, 16'h010C);
  endtask

  task automatic t_rev();
    logic [15:0] v, exp;
    span = 5'd3;
    load(0, 4, 16'h00A0);
    exp = 16'h00A0;
    for (int k = 0; k < 9; k++) begin
      acc0(4, 4, 0);
      #1 chk_eq("R5 bit-reversed walk", addr[0], exp);
      check((addr[0] & 16'hFFF8) == 16'h00A0, "R6 upper bits kept", addr[0], exp);
      if (k == 1) chk_eq("R5 second reversed address", addr[0], 16'h00A4);
      step();
      exp = rev_model(exp, 3);
    end
    span = 5'd0;
    acc0(4, 4, 0); step();
    peek(4, v); chk_eq("R6 zero span", v, rev_model(16'h00A0, 3));
    span = 5'd16;
    load(0, 4, 16'h0000);
    acc0(4, 4, 0); step();
    peek(4, v); chk_eq("R5 full-width reverse", v, 16'h8000);
    span = 5'd0;
  endtask

  task automatic t_multi();
    logic [15:0] v;
    load(0, 5, 16'h0010);
    load(0, 6, 16'h0020);
    load(0, 7, 16'h0030);
    load(1, 1, 16'h0003);
    en = 3'b111;
    ptr[0] = 3'd5; mode[0] = 3'd1;
    ptr[1] = 3'd6; mode[1] = 3'd2;
    ptr[2] = 3'd7; mode[2] = 3'd3; idx[2] = 2'd1;
    #1;
    chk_eq("R8 port0 address", addr[0], 16'h0010);
    chk_eq("R8 port1 address", addr[1], 16'h0020);
    chk_eq("R8 port2 address", addr[2], 16'h0030);
    step();
    peek(5, v); chk_eq("R8 port0 update", v, 16'h0012);
    peek(6, v); chk_eq("R8 port1 update", v, 16'h001E);
    peek(7, v); chk_eq("R8 port2 update", v, 16'h0033);
  endtask

  task automatic t_conflict();
    logic [15:0] v;
    load(0, 0, 16'h0040);
    en = 3'b101;
    ptr[0] = 3'd0; mode[0] = 3'd1;
    ptr[2] = 3'd0; mode[2] = 3'd2;
    step();
    peek(0, v); chk_eq("R9 port0 beats port2", v, 16'h0042);
    en = 3'b110;
    ptr[1] = 3'd0; mode[1] = 3'd3; idx[1] = 2'd1;
    ptr[2] = 3'd0; mode[2] = 3'd1;
    step();
    peek(0, v); chk_eq("R9 port1 beats port2", v, 16'h0045);
  endtask

  task automatic t_undef();
    logic [15:0] v;
    for (int m = 5; m < 8; m++) begin
      acc0(5, m, 0); step();
      peek(5, v); chk_eq("R12 undefined mode holds", v, 16'h0012);
    end
  endtask

  task automatic t_load();
    logic [15:0] v;
    acc0(6, 1, 0);
    ld_en = 1'b1; ld_kind = 1'b0; ld_reg = 3'd6; ld_data = 16'h0777;
    step();
    peek(6, v); chk_eq("R10 load beats port update", v, 16'h0777);
    load(1, 2, 16'h0005);
    peek(6, v); chk_eq("R10 index load leaves pointers", v, 16'h0777);
    peek(2, v); chk_eq("R10 index load leaves pointer 2", v, 16'hFFFE);
  endtask

  initial begin
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_rev();
    t_multi();
    t_conflict();
    t_undef();
    t_load();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule